// File: doc/BRIEF.md
# Multi-Lane Deskew Release Buffer

This block takes user data from several serial lanes that reach the receiver at different times. It holds each lane in its own elastic buffer and releases all of them in the same clock, so that word k of every lane leaves the block in the same cycle. Each lane starts filling its buffer at its own start-of-user-data marker. Reading is shared by all lanes and begins once the release decision is made.

The release point is tied to the local multiframe counter. The counter runs from 0 up to the programmed multiframe length minus one; its last count is the multiframe boundary. A programmable offset moves the release to a number of link clocks before that boundary. A force mode, an out-of-range offset, or disabled lane synchronisation instead releases the data as soon as the last lane has arrived. The block also reports where in the multiframe the latest lane arrived. It raises a sticky deskew error when the lanes cannot all be absorbed: either their starts are spread over more than one multiframe, or a buffer fills up before release.

Top module: `lane_deskew_release`

## Requirements
- R1: After reset, aligned_valid_o and deskew_err_o are 0, arrival_cnt_o is 0, every lane_empty_o bit is 1 and every lane_full_o bit is 0.
- R2: A lane starts storing one word per clock in the cycle its start bit is high, and it ignores later start pulses. After release, each output word carries the k-th word stored by every lane, with lane i in bits [i*DATA_W +: DATA_W].
- R3: Normal release applies when lane sync is enabled, force is low and offset ≤ mf_len. Release then happens in the first cycle after the latest lane's start cycle in which lmfc_cnt_i == mf_len − offset; mf_len is the multiframe length minus one and is the boundary count. aligned_valid_o goes high one clock after the release cycle and stays high until reset.
- R4: An offset greater than mf_len releases the data in the cycle after the latest start, so aligned_valid_o rises two clocks after that start.
- R5: A high force input overrides the offset: release happens in the cycle after the latest start.
- R6: arrival_cnt_o takes the value mf_len − lmfc_cnt_i sampled in the latest lane's start cycle (0 if lmfc_cnt_i > mf_len). It shows that value one clock later and holds it until reset.
- R7: With lane sync enabled, if some lane has still not started more than mf_len clocks after the first start, deskew_err_o is set one clock later. It stays set until reset.
- R8: With lane sync disabled, the offset is ignored, release happens in the cycle after the latest start, and no skew error is raised.
- R9: lane_empty_o[i] is 1 when lane i holds no words and lane_full_o[i] is 1 when it holds DEPTH words. After release, the occupancy of each lane stays constant.
- R10: A write to a full lane before release is dropped and sets deskew_err_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | NUM_LANES*DATA_W | Per-lane received words |
| lane_start_i | input | NUM_LANES | Per-lane start-of-user-data marker |
| lmfc_cnt_i | input | CNT_W | Local multiframe counter |
| cfg_rel_offset_i | input | CNT_W | Release offset in link clocks before the boundary |
| cfg_force_rel_i | input | 1 | Release as soon as the last lane has arrived |
| cfg_lane_sync_en_i | input | 1 | Lane synchronisation enable |
| cfg_mf_len_i | input | CNT_W | Multiframe length in link clocks minus one |
| aligned_data_o | output | NUM_LANES*DATA_W | Deskewed words of all lanes |
| aligned_valid_o | output | 1 | Aligned data valid |
| arrival_cnt_o | output | CNT_W | Latest lane position before the boundary |
| deskew_err_o | output | 1 | Sticky skew or overflow error |
| lane_empty_o | output | NUM_LANES | Per-lane buffer empty |
| lane_full_o | output | NUM_LANES | Per-lane buffer full |

## Verification
Buffer overflow is the hardest condition to reach. It needs a lane that is held for longer than DEPTH clocks while the lane skew still stays inside one multiframe, so that the skew check does not fire first. The stimulus sets a long multiframe and a counter phase that makes the latest lane arrive just after the release count, which pushes the release a full multiframe later. It also adds repeated start pulses and lane skews that land exactly on the release count. A behavioural model built on queues follows every one of these cases clock by clock.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_STREAM = 1'b1
  } rel_state_e;
endpackage

// File: rtl/dsk_lane_buf.sv
module dsk_lane_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              wr_ok;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign wr_ok     = wr_i & (~full_o | rd_i);
  assign ovf_o     = wr_i & full_o & ~rd_i;
  assign rd_data_o = rd_data_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      rd_data_q <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      if (rd_i) begin
        rd_data_q <= mem_q[rd_ptr_q];
        rd_ptr_q  <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      end
      case ({wr_ok, rd_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9: release never reads a lane that holds nothing
  p_rd_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);

  // R9: occupancy moves by at most one word per clock
  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1)) ||
    (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dsk_arrival_trk.sv
module dsk_arrival_trk #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] start_i,
  input  logic [CNT_W-1:0]     lmfc_cnt_i,
  input  logic [CNT_W-1:0]     mf_len_i,
  input  logic                 sync_en_i,
  input  logic [NUM_LANES-1:0] ovf_i,
  output logic [NUM_LANES-1:0] arrived_o,
  output logic                 all_arrived_o,
  output logic [CNT_W-1:0]     arr_cnt_o,
  output logic                 err_o
);
  localparam int EW = CNT_W + 1;

  logic [NUM_LANES-1:0] arr_q, arr_d;
  logic [EW-1:0]        el_q;
  logic [CNT_W-1:0]     arr_cnt_q;
  logic                 err_q;
  logic                 some_q, all_q, last_now, skew_err;

  assign some_q   = |arr_q;
  assign all_q    = &arr_q;
  assign arr_d    = arr_q | start_i;
  assign last_now = (&arr_d) & ~all_q;
  // elapsed clocks since first start exceed one multiframe with a lane missing
  assign skew_err = sync_en_i & some_q & ~all_q & (el_q > {1'b0, mf_len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q     <= '0;
      el_q      <= '0;
      arr_cnt_q <= '0;
      err_q     <= 1'b0;
    end else begin
      arr_q <= arr_d;
      if (!some_q && |start_i)              el_q <= EW'(1);
      else if (some_q && !all_q && ~&el_q)  el_q <= el_q + EW'(1);
      if (last_now)
        arr_cnt_q <= (lmfc_cnt_i <= mf_len_i) ? (mf_len_i - lmfc_cnt_i) : '0;
      if (skew_err || |ovf_i) err_q <= 1'b1;
    end
  end

  assign arrived_o     = arr_q;
  assign all_arrived_o = all_q;
  assign arr_cnt_o     = arr_cnt_q;
  assign err_o         = err_q;

  // R7: the error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  // R10: an overflow on any lane leads to the error flag
  p_ovf_sets_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> err_q);

  // R2: once a lane has started it stays started
  p_arrived_mono_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((arr_q & $past(arr_q)) == $past(arr_q)));
endmodule

// File: rtl/dsk_release_ctrl.sv
module dsk_release_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             all_arrived_i,
  input  logic [CNT_W-1:0] lmfc_cnt_i,
  input  logic [CNT_W-1:0] mf_len_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic             force_i,
  input  logic             sync_en_i,
  output logic             rd_o,
  output logic             valid_o
);
  import dsk_pkg::*;

  rel_state_e       state_q;
  logic             valid_q;
  logic [CNT_W-1:0] target;
  logic             off_bad, bypass, at_point, rel_go;

  assign target   = mf_len_i - offset_i;
  assign off_bad  = offset_i > mf_len_i;
  assign bypass   = ~sync_en_i | force_i | off_bad;
  assign at_point = (lmfc_cnt_i == target);
  assign rel_go   = (state_q == ST_ARMED) & all_arrived_i & (bypass | at_point);
  assign rd_o     = (state_q == ST_STREAM) | rel_go;
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      valid_q <= 1'b0;
    end else begin
      if (rel_go) state_q <= ST_STREAM;
      valid_q <= rd_o;
    end
  end

  // R3: once streaming, valid never drops
  p_valid_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);

  // R3: reading only starts after every lane has arrived
  p_rd_after_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |-> all_arrived_i);
endmodule

// File: rtl/lane_deskew_release.sv
module lane_deskew_release #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 32,
  parameter int CNT_W     = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LANES-1:0][DATA_W-1:0] lane_data_i,
  input  logic [NUM_LANES-1:0]             lane_start_i,
  input  logic [CNT_W-1:0]                 lmfc_cnt_i,
  input  logic [CNT_W-1:0]                 cfg_rel_offset_i,
  input  logic                             cfg_force_rel_i,
  input  logic                             cfg_lane_sync_en_i,
  input  logic [CNT_W-1:0]                 cfg_mf_len_i,
  output logic [NUM_LANES-1:0][DATA_W-1:0] aligned_data_o,
  output logic                             aligned_valid_o,
  output logic [CNT_W-1:0]                 arrival_cnt_o,
  output logic                             deskew_err_o,
  output logic [NUM_LANES-1:0]             lane_empty_o,
  output logic [NUM_LANES-1:0]             lane_full_o
);
  logic [NUM_LANES-1:0] arrived, ovf;
  logic                 all_arrived, rd;

  dsk_arrival_trk #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (lane_start_i),
    .lmfc_cnt_i   (lmfc_cnt_i),
    .mf_len_i     (cfg_mf_len_i),
    .sync_en_i    (cfg_lane_sync_en_i),
    .ovf_i        (ovf),
    .arrived_o    (arrived),
    .all_arrived_o(all_arrived),
    .arr_cnt_o    (arrival_cnt_o),
    .err_o        (deskew_err_o)
  );

  dsk_release_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .all_arrived_i(all_arrived),
    .lmfc_cnt_i   (lmfc_cnt_i),
    .mf_len_i     (cfg_mf_len_i),
    .offset_i     (cfg_rel_offset_i),
    .force_i      (cfg_force_rel_i),
    .sync_en_i    (cfg_lane_sync_en_i),
    .rd_o         (rd),
    .valid_o      (aligned_valid_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    dsk_lane_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (lane_start_i[l] | arrived[l]),
      .data_i   (lane_data_i[l]),
      .rd_i     (rd),
      .rd_data_o(aligned_data_o[l]),
      .empty_o  (lane_empty_o[l]),
      .full_o   (lane_full_o[l]),
      .ovf_o    (ovf[l])
    );
  end

  // R3: when valid first rises, every lane held data in the release cycle
  p_release_nonempty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_valid_o) |-> ($past(lane_empty_o) == '0));
endmodule

// File: tb/lane_deskew_release_tb.sv
module lane_deskew_release_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0][DW-1:0] ldata = '0;
  logic [NL-1:0] lstart = '0;
  logic [CW-1:0] lmfc = '0, off = '0, mf = 8'd7;
  logic frc = 1'b0, sen = 1'b1;
  logic [NL-1:0][DW-1:0] adata;
  logic avalid, derr;
  logic [CW-1:0] acnt;
  logic [NL-1:0] lempty, lfull;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_deskew_release u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lane_data_i(ldata), .lane_start_i(lstart),
    .lmfc_cnt_i(lmfc), .cfg_rel_offset_i(off), .cfg_force_rel_i(frc),
    .cfg_lane_sync_en_i(sen), .cfg_mf_len_i(mf), .aligned_data_o(adata),
    .aligned_valid_o(avalid), .arrival_cnt_o(acnt), .deskew_err_o(derr),
    .lane_empty_o(lempty), .lane_full_o(lfull)
  );

  // behavioural reference model
  logic [DW-1:0] mq [NL][$];
  logic [NL-1:0] m_arr;
  int m_el;
  bit m_rel, m_err, m_valid;
  int m_acnt;
  logic [NL-1:0][DW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arr = '0; m_el = 0; m_rel = 0; m_err = 0; m_valid = 0; m_acnt = 0;
      m_data = '0;
      for (int l = 0; l < NL; l++) mq[l].delete();
    end else begin
      bit some, allp, errs, relg, reading;
      int sz [NL];
      some = |m_arr;
      allp = &m_arr;
      errs = sen && some && !allp && (m_el > int'(mf));
      relg = allp && !m_rel &&
             (!sen || frc || (off > mf) || (int'(lmfc) == int'(mf) - int'(off)));
      reading = m_rel || relg;
      for (int l = 0; l < NL; l++) sz[l] = mq[l].size();
      if (reading)
        for (int l = 0; l < NL; l++) m_data[l] = mq[l].pop_front();
      m_valid = reading;
      for (int l = 0; l < NL; l++) begin
        if (lstart[l] || m_arr[l]) begin
          if (sz[l] == DEPTH && !reading) errs = 1;
          else mq[l].push_back(ldata[l]);
        end
      end
      if (!some && |lstart) m_el = 1;
      else if (some && !allp) m_el++;
      if (!allp && &(m_arr | lstart))
        m_acnt = (lmfc <= mf) ? int'(mf) - int'(lmfc) : 0;
      m_arr = m_arr | lstart;
      m_err = m_err || errs;
      m_rel = m_rel || relg;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [NL*DW-1:0] act, input logic [NL*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk({"R3 ", tag}, "valid", NL*DW'(avalid), NL*DW'(m_valid));
    if (m_valid) chk({"R2 ", tag}, "data", adata, m_data);
    chk({"R6 ", tag}, "arrival_cnt", NL*DW'(acnt), NL*DW'(m_acnt));
    chk({"R7 ", tag}, "deskew_err", NL*DW'(derr), NL*DW'(m_err));
    for (int l = 0; l < NL; l++) begin
      chk({"R9 ", tag}, "empty", NL*DW'(lempty[l]), NL*DW'(mq[l].size() == 0));
      chk({"R9 ", tag}, "full", NL*DW'(lfull[l]), NL*DW'(mq[l].size() == DEPTH));
    end
  endtask

  task automatic run_case(input string tag, input int c_mf, input int c_off,
                          input bit c_frc, input bit c_sen, input int d0, input int d1,
                          input int d2, input int d3, input int lst, input int ncyc,
                          input int exp_first, input int exp_acnt, input bit exp_err);
    int dl [NL];
    int first = -1;
    dl[0] = d0; dl[1] = d1; dl[2] = d2; dl[3] = d3;
    @(negedge clk);
    rst_n = 1'b0; lstart = '0;
    mf = CW'(c_mf); off = CW'(c_off); frc = c_frc; sen = c_sen;
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        compare(tag);
        if (avalid && first < 0) first = cyc;
      end
      lmfc = CW'((lst + cyc) % (c_mf + 1));
      for (int l = 0; l < NL; l++) begin
        lstart[l] = (cyc == dl[l]) || (cyc == dl[l] + 3);  // R2: repeat pulse ignored
        ldata[l]  = $urandom;
      end
    end
    @(negedge clk);
    lstart = '0;
    chk({tag, " release cycle"}, "first_valid", NL*DW'(first), NL*DW'(exp_first));
    chk({"R6 ", tag}, "arrival_cnt", NL*DW'(acnt), NL*DW'(exp_acnt));
    chk({"R7 ", tag}, "deskew_err", NL*DW'(derr), NL*DW'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid", NL*DW'(avalid), '0);
    chk("R1", "deskew_err", NL*DW'(derr), '0);
    chk("R1", "arrival_cnt", NL*DW'(acnt), '0);
    chk("R1", "empty", NL*DW'(lempty), NL*DW'({NL{1'b1}}));
    chk("R1", "full", NL*DW'(lfull), '0);
    //        tag    mf off frc sen  delays        lst ncyc first acnt err
    run_case("R3",    7, 0, 0, 1,   1, 3, 2, 4,   0,  40,  8,    3,  0);
    run_case("R3",    7, 3, 0, 1,   2, 0, 1, 3,   0,  40,  5,    4,  0);
    run_case("R3",    7, 3, 0, 1,   4, 0, 1, 2,   0,  40, 13,    3,  0);
    run_case("R4",    7, 9, 0, 1,   0, 1, 2, 3,   0,  40,  5,    4,  0);
    run_case("R5",    7, 3, 1, 1,   0, 2, 5, 1,   0,  40,  7,    2,  0);
    run_case("R8",    7, 2, 0, 0,   6, 0, 3, 1,   0,  40,  8,    1,  0);
    run_case("R8",    7, 0, 0, 0,   0, 9, 1, 2,   0,  40, 11,    6,  0);
    run_case("R7",    7, 0, 0, 1,   0, 9, 1, 2,   0,  40, 16,    6,  1);
    run_case("R10",  31, 0, 0, 1,   0, 20, 1, 2, 12,  80, 52,   31,  1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule